// File: doc/BRIEF.md
# Fixed-Sequence Seven-Segment Digit Generator

This block walks through a fixed list of eight decimal digits and drives one seven-segment display with the digit at the current position. The list, from position 0 to position 7, is 1, 5, 6, 6, 9, 5, 5, 7. It is not monotonic and it repeats values. The 3-bit position comes from one of two sources, chosen by a parameter. The first source is an internal counter that moves on each clock edge where the advance input is high. The second is three external bit-generator inputs that are captured on each such edge.

The position goes through a 3-to-8 one-hot decoder built from AND and NOT terms. Each of the seven segments is then the OR of the decoder lines at which that segment is lit. No behavioural lookup takes part in the segment logic. The segment-to-position masks are constants computed when the design is elaborated. The segment outputs follow the registered position combinationally.

Top module: `digit_sequence_display`

## Requirements
- R1: With the clock running, a high synchronous reset sets the position output to 0 at the next rising edge, so the display shows digit 1.
- R2: In counter mode (UseExternal = 0), each rising edge with advance high and reset low raises the position by exactly one.
- R3: A rising edge with advance low and reset low leaves the position unchanged in both modes.
- R4: In counter mode the position wraps from 7 to 0 on an advancing edge.
- R5: The segment output `segments` is ordered a at bit 0 through g at bit 6, and a 1 lights a segment. It equals 7'h06 for digit 1, 7'h6D for digit 5, 7'h7D for digit 6, 7'h6F for digit 9 and 7'h07 for digit 7. The digit at positions 0..7 is 1, 5, 6, 6, 9, 5, 5, 7.
- R6: The segments show the pattern of the new position in the same cycle that the position changes, with no extra register stage.
- R7: Exactly one decoder line is active for every position. As a result, each position shows only its own digit's pattern, with no segment taken from another position.
- R8: In external mode (UseExternal = 1), each rising edge with advance high and reset low loads the position from `extIndex`.
- R9: Reset takes priority over advance in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step (counter mode) or capture (external mode) enable |
| extIndex | input | 3 | Position from external bit generators; used only in external mode |
| segments | output | 7 | Segment lines a..g at bits 0..6, active high |
| curIndex | output | 3 | Current registered position |

## Verification
The hardest situation to reach from the ports is a break in the one-hot property of the decoder. Two lines active at once would only show up as extra lit segments at particular positions. Segment c is lit at every position and therefore hides any such overlap on that segment. The stimulus visits all eight positions twice in counter mode and compares the whole seven-bit pattern exactly at each one. Random external positions, mixed with random advance and reset, reach every position again and also cover jumps between distant positions in a single cycle.

// File: rtl/seqdig_pkg.sv
package seqdig_pkg;

  localparam int SegCount = 7;
  localparam int DigitBits = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic step;
    logic load;
  } seqStrobes_t;

  // Elaboration-time pattern of a decimal digit: bit 0 = a ... bit 6 = g
  function automatic logic [SegCount-1:0] segmentsOfDigit(input logic [DigitBits-1:0] digit);
    logic [SegCount-1:0] pat;
    case (digit)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/seqdig_control.sv
module seqdig_control #(
  parameter bit UseExternal = 1'b0
) (
  input  logic                     rst,
  input  logic                     advance,
  output seqdig_pkg::seqStrobes_t  ctl
);

  logic moveReq;
  assign moveReq = advance & ~rst;

  generate
    if (UseExternal) begin : gExternal
      assign ctl.step = 1'b0;
      assign ctl.load = moveReq;
    end else begin : gCounter
      assign ctl.step = moveReq;
      assign ctl.load = 1'b0;
    end
  endgenerate

  assign ctl.clear = rst;

  // R9: a clear never coexists with a move strobe
  always_comb begin
    assert_clear_alone_R9: assert (!(ctl.clear && (ctl.step || ctl.load)))
      else $error("clear issued together with a move strobe");
  end

endmodule

// File: rtl/seqdig_decoder.sv
module seqdig_decoder #(
  parameter int IdxWidth = 3,
  localparam int Steps = 1 << IdxWidth
) (
  input  logic [IdxWidth-1:0] idx,
  output logic [Steps-1:0]    lines
);

  generate
    for (genvar i = 0; i < Steps; i++) begin : gLine
      logic [IdxWidth-1:0] lit;
      for (genvar j = 0; j < IdxWidth; j++) begin : gBit
        if (((i >> j) & 1) == 1) begin : gTrue
          assign lit[j] = idx[j];
        end else begin : gInv
          assign lit[j] = ~idx[j];
        end
      end
      assign lines[i] = &lit;
    end
  endgenerate

endmodule

// File: rtl/seqdig_segmap.sv
module seqdig_segmap #(
  parameter int IdxWidth = 3,
  localparam int Steps = 1 << IdxWidth,
  parameter logic [Steps*seqdig_pkg::DigitBits-1:0] DigitList = 32'h7559_6651
) (
  input  logic [Steps-1:0]                  lines,
  output logic [seqdig_pkg::SegCount-1:0]   segOut
);

  function automatic logic [Steps-1:0] maskFor(input int seg);
    logic [Steps-1:0] m;
    logic [seqdig_pkg::SegCount-1:0] p;
    m = '0;
    for (int i = 0; i < Steps; i++) begin
      p = seqdig_pkg::segmentsOfDigit(DigitList[i*seqdig_pkg::DigitBits +: seqdig_pkg::DigitBits]);
      m[i] = p[seg];
    end
    return m;
  endfunction

  generate
    for (genvar s = 0; s < seqdig_pkg::SegCount; s++) begin : gSeg
      localparam logic [Steps-1:0] LitMask = maskFor(s);
      assign segOut[s] = |(lines & LitMask);
    end
  endgenerate

endmodule

// File: rtl/seqdig_datapath.sv
module seqdig_datapath #(
  parameter int IdxWidth = 3,
  localparam int Steps = 1 << IdxWidth,
  parameter logic [Steps*seqdig_pkg::DigitBits-1:0] DigitList = 32'h7559_6651
) (
  input  logic                              clk,
  input  seqdig_pkg::seqStrobes_t           ctl,
  input  logic [IdxWidth-1:0]               loadValue,
  output logic [IdxWidth-1:0]               idxQ,
  output logic [seqdig_pkg::SegCount-1:0]   segOut
);

  logic [Steps-1:0] lines;

  always_ff @(posedge clk) begin
    if (ctl.clear)     idxQ <= '0;
    else if (ctl.step) idxQ <= idxQ + 1'b1;
    else if (ctl.load) idxQ <= loadValue;
  end

  seqdig_decoder #(.IdxWidth(IdxWidth)) decodeU (
    .idx   (idxQ),
    .lines (lines)
  );

  seqdig_segmap #(.IdxWidth(IdxWidth), .DigitList(DigitList)) segmapU (
    .lines  (lines),
    .segOut (segOut)
  );

  assert_reset_zero_R1: assert property (@(posedge clk) ctl.clear |=> idxQ == '0)
    else $error("position not zero after clear");

  assert_step_wrap_R2: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.step |=> idxQ == IdxWidth'($past(idxQ) + 1'b1))
    else $error("step did not add one modulo the position range");

  assert_hold_R3: assert property (@(posedge clk) disable iff (ctl.clear)
    (!ctl.step && !ctl.load) |=> $stable(idxQ))
    else $error("position moved without a strobe");

  assert_load_R8: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.load |=> idxQ == $past(loadValue))
    else $error("external position not captured");

  assert_onehot_R7: assert property (@(posedge clk) disable iff (ctl.clear)
    $countones(lines) == 1)
    else $error("decoder lines not one-hot");

  assert_seg_match_R5: assert property (@(posedge clk) disable iff (ctl.clear)
    segOut == seqdig_pkg::segmentsOfDigit(DigitList[int'(idxQ)*seqdig_pkg::DigitBits +: seqdig_pkg::DigitBits]))
    else $error("segment pattern does not match listed digit");

endmodule

// File: rtl/digit_sequence_display.sv
module digit_sequence_display #(
  parameter bit UseExternal = 1'b0,
  parameter int IdxWidth = 3,
  localparam int Steps = 1 << IdxWidth,
  parameter logic [Steps*seqdig_pkg::DigitBits-1:0] DigitList = 32'h7559_6651
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             advance,
  input  logic [IdxWidth-1:0]              extIndex,
  output logic [seqdig_pkg::SegCount-1:0]  segments,
  output logic [IdxWidth-1:0]              curIndex
);

  seqdig_pkg::seqStrobes_t ctl;

  seqdig_control #(.UseExternal(UseExternal)) controlU (
    .rst     (rst),
    .advance (advance),
    .ctl     (ctl)
  );

  seqdig_datapath #(.IdxWidth(IdxWidth), .DigitList(DigitList)) datapathU (
    .clk       (clk),
    .ctl       (ctl),
    .loadValue (extIndex),
    .idxQ      (curIndex),
    .segOut    (segments)
  );

endmodule

// File: tb/digit_sequence_display_test.sv
module digit_sequence_display_test;

  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0;
  logic [2:0] extIndex = 3'd0;
  logic [6:0] segCnt, segExt;
  logic [2:0] idxCnt, idxExt;

  int checks = 0;
  int errors = 0;
  int expCnt = 0;
  int expExt = 0;

  always #(ClkPeriod/2) clk = ~clk;

  digit_sequence_display #(.UseExternal(1'b0)) uut (
    .clk(clk), .rst(rst), .advance(advance), .extIndex(extIndex),
    .segments(segCnt), .curIndex(idxCnt)
  );

  digit_sequence_display #(.UseExternal(1'b1)) uutExt (
    .clk(clk), .rst(rst), .advance(advance), .extIndex(extIndex),
    .segments(segExt), .curIndex(idxExt)
  );

  function automatic int digitAt(input int pos);
    case (pos)
      0: return 1;
      1: return 5;
      2: return 6;
      3: return 6;
      4: return 9;
      5: return 5;
      6: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int patternOf(input int pos);
    case (digitAt(pos))
      1: return 'h06;
      5: return 'h6D;
      6: return 'h7D;
      9: return 'h6F;
      default: return 'h07;
    endcase
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let the rising edge act, sample just after.
  task automatic cycle(input logic r, input logic a, input logic [2:0] e);
    @(negedge clk);
    rst = r; advance = a; extIndex = e;
    @(posedge clk);
    if (r) begin
      expCnt = 0; expExt = 0;
    end else if (a) begin
      expCnt = (expCnt + 1) % 8;
      expExt = int'(e);
    end
    #1;
  endtask

  task automatic checkBoth(input string tag);
    checkVal({tag, " counter index"}, int'(idxCnt), expCnt);
    checkVal({tag, " counter segments"}, int'(segCnt), patternOf(expCnt));
    checkVal({tag, " external index"}, int'(idxExt), expExt);
    checkVal({tag, " external segments"}, int'(segExt), patternOf(expExt));
  endtask

  initial begin
    #(ClkPeriod * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1: reset state shows digit 1
    cycle(1'b1, 1'b0, 3'd0);
    cycle(1'b1, 1'b0, 3'd0);
    checkBoth("R1 reset");
    checkVal("R1 reset pattern literal", int'(segCnt), 'h06);

    // R2 R4 R5 R6 R7: two full wraps in counter mode, every position compared exactly
    for (int n = 0; n < 16; n++) begin
      cycle(1'b0, 1'b1, 3'(n));
      checkVal("R2 R4 step index", int'(idxCnt), (n + 1) % 8);
      checkVal("R5 R6 R7 segments same cycle", int'(segCnt), patternOf((n + 1) % 8));
    end
    checkVal("R4 wrapped back to 0", int'(idxCnt), 0);

    // R3: advance low holds position in both modes
    cycle(1'b0, 1'b1, 3'd6);
    for (int n = 0; n < 3; n++) begin
      cycle(1'b0, 1'b0, 3'(n));
      checkBoth("R3 hold");
    end

    // R8: external loads at distant jumps
    cycle(1'b0, 1'b1, 3'd7);
    checkVal("R8 load 7", int'(idxExt), 7);
    cycle(1'b0, 1'b1, 3'd0);
    checkVal("R8 load 0", int'(idxExt), 0);
    cycle(1'b0, 1'b1, 3'd4);
    checkVal("R8 load 4 segments", int'(segExt), 'h6F);

    // R9: reset beats advance
    cycle(1'b1, 1'b1, 3'd5);
    checkBoth("R9 reset priority");
    checkVal("R9 external index cleared", int'(idxExt), 0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic r, a;
      logic [2:0] e;
      r = (($urandom % 20) == 0);
      a = $urandom % 2;
      e = 3'($urandom);
      cycle(r, a, e);
      checkBoth("R2 R3 R5 R8 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule